// File: doc/BRIEF.md
# Dual-Area DRAM Controller

This block sits behind a processor bus and turns read and write requests aimed at two address areas (area 2 and area 3) into RAS/CAS cycles for directly attached DRAM. A 3-bit map field chooses how DRAM is laid out. With one value only area 3 is DRAM, and its width can be 16 or 32 bits. With a second value both areas are DRAM, each 16 bits wide and each with its own RAS and CAS strobes. With any other value neither area is DRAM and requests are dropped. Byte selection is done through the CAS lines. A single read/write line is shared by both areas.

A request carries a row/column word address, byte enables and a burst length of 1, 2, 4 or 8 beats. The controller opens the row, then runs one CAS pulse per beat in fast-page fashion while RAS stays low. It closes the row with a precharge of at least one clock. Reads on area 3 may use extended-data-out timing: the data is latched half a clock later, on the falling edge after CAS rises. A refresh request input starts a CAS-before-RAS cycle on every RAS line that is mapped as DRAM. It is taken only when the controller is idle.

Top module: `dram_area_ctrl`

## Requirements
- R1: `dram_map` = 3'b100 maps only area 3 (`req_area`=1) as DRAM, and 3'b101 maps both areas. For any other value, and for area 2 under 3'b100, a request gets no `req_ack` and every strobe stays high.
- R2: On area 3, `cas_n[3:0]` drive the byte lanes from most to least significant (bit 3 = byte 3 ... bit 0 = byte 0), each low when its `req_be` bit is set. The area is 32 bits wide only when `dram_map`=3'b100 and `a3_wide32`=1; when it is 16 bits wide, `cas_n[3:2]` stay high.
- R3: An area-2 access drives `ras2_n` and `cas2_n` (bit 1 = high byte from `req_be[1]`, bit 0 = low byte from `req_be[0]`) and leaves `ras_n` and `cas_n` high. An area-3 access leaves `ras2_n` and `cas2_n` high.
- R4: One cycle after acceptance, RAS is low, all CAS lines are high and `dram_addr` holds the row (`req_addr[ADDR_W-1:COL_W]`). After that, CAS goes low with the column on `dram_addr`.
- R5: `req_len` codes 0..3 give 1, 2, 4 and 8 beats. RAS stays low for the whole burst. Each beat holds CAS low for two cycles, with `beat_rdy` high in the second cycle, and CAS is high for one cycle between beats. Beat n uses column (`req_addr[COL_W-1:0]` + n) mod 2^COL_W.
- R6: After RAS rises it stays high for at least one further clock, and all strobes are high once the burst has ended.
- R7: In normal timing, a read beat gives `rd_valid` for exactly one cycle, the cycle after its `beat_rdy`. `rd_data` holds the DRAM data present while CAS was low.
- R8: With `edo_en`=1 on area 3, read data is latched on the falling clock edge after CAS rises, and `rd_valid` comes two cycles after `beat_rdy`. On area 2, `edo_en` has no effect.
- R9: During a write, `dram_we_n` is low while RAS is active, `dq_oe` is high while CAS is low, and `dq_out` equals `wdata`. During a read, `dram_we_n` is high and `dq_oe` is low.
- R10: After reset, all RAS and CAS lines and `dram_we_n` are high, and `beat_rdy`, `rd_valid` and `dq_oe` are low.
- R11: A refresh request is taken only in idle and wins over a pending access. It drives CAS low for one cycle with RAS high, then RAS low on every mapped RAS line, then precharge. During the refresh, the CAS lanes are all four for a 32-bit area 3 and the low two otherwise, plus both `cas2_n` lines when both areas are mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_map | input | 3 | DRAM map field (3'b100 / 3'b101) |
| a3_wide32 | input | 1 | Area 3 is 32 bits wide when the map allows it |
| edo_en | input | 1 | Extended-data-out read timing for area 3 |
| req_valid | input | 1 | Access request |
| req_area | input | 1 | 1 = area 3, 0 = area 2 |
| req_write | input | 1 | 1 = write |
| req_addr | input | ROW_W+COL_W | Word address {row, column} |
| req_be | input | 4 | Byte enables, bit n = byte lane n |
| req_len | input | 2 | Burst code: 1, 2, 4, 8 beats |
| req_ack | output | 1 | Request taken this cycle |
| beat_rdy | output | 1 | One beat completes this cycle |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle per beat |
| refresh_req | input | 1 | Refresh request |
| refresh_ack | output | 1 | Refresh taken this cycle |
| ras_n | output | 1 | Area 3 row strobe, active low |
| ras2_n | output | 1 | Area 2 row strobe, active low |
| cas_n | output | 4 | Area 3 column strobes, active low |
| cas2_n | output | 2 | Area 2 column strobes, active low |
| dram_we_n | output | 1 | Shared write line, low = write |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | 32 | Data driven to DRAM |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 32 | Data from DRAM |

## Verification
The assertions check on every cycle the rules that hold whatever was requested. The upper area-3 lanes stay quiet when the area is 16 bits wide, RAS stays high for at least one clock after it rises, and CAS falls while every RAS line is high only in the first refresh cycle. Both RAS lines are low together only during refresh, an unmapped map value leaves the strobes high, and a read-valid pulse lasts one cycle. Only the bench scenarios can show the things that depend on the request: which lanes and columns each beat drives, the beat count per burst code, the one-cycle or two-cycle read latency and the data it returns, and refresh priority and deferral. The bench shows these by sweeping map value, area, width, direction, burst length and read timing against a DRAM model.

// File: rtl/dram_area_pkg.sv
// Shared types for the dual-area DRAM controller.
// Assumes: map codes are fixed by the bus-level configuration field.
package dram_area_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ROW, ST_COL, ST_DATA, ST_CGAP, ST_PRE, ST_CBR_C, ST_CBR_R
    } dstate_t;

    localparam logic [2:0] MAP_A3_ONLY = 3'b100;
    localparam logic [2:0] MAP_BOTH    = 3'b101;
endpackage

// File: rtl/dram_lane_decode.sv
// Byte-lane decoder: turns byte enables into active-high CAS lane masks.
// Assumes: area-3 lanes are ordered byte 3..0, area 2 uses bytes 1..0,
// and a refresh cycle strobes every lane of every mapped area.
module dram_lane_decode (
    input  logic       to_a3,
    input  logic       wide,
    input  logic       two_area,
    input  logic       cbr,
    input  logic [3:0] be,
    output logic [3:0] a3_lanes,
    output logic [1:0] a2_lanes
);
    // Select lanes for refresh, area-3 access or area-2 access.
    always_comb begin
        if (cbr) begin
            a3_lanes = wide ? 4'hF : 4'h3;
            a2_lanes = two_area ? 2'b11 : 2'b00;
        end else if (to_a3) begin
            a3_lanes = wide ? be : {2'b00, be[1:0]};
            a2_lanes = 2'b00;
        end else begin
            a3_lanes = 4'h0;
            a2_lanes = be[1:0];
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Row/column multiplexer for the DRAM address pins.
// Assumes: the column advances by the beat index and wraps inside COL_W bits.
module dram_addr_mux #(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 8,
    parameter int BEAT_W = 3,
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              sel_row,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [BEAT_W-1:0] beat,
    output logic [MA_W-1:0]   ma
);
    logic [COL_W-1:0] col_eff;

    // Column of the current beat, then pick row or column.
    always_comb begin
        col_eff = col + COL_W'(beat);
        ma      = sel_row ? MA_W'(row) : MA_W'(col_eff);
    end
endmodule

// File: rtl/dram_edo_capture.sv
// Read data capture with normal or extended-data-out sampling.
// Normal: latch on the rising edge that ends the CAS cycle.
// EDO: latch on the next falling edge, present on the following rising edge.
// Assumes: samp is a one-cycle pulse during the last CAS cycle of a read beat.
module dram_edo_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp,
    input  logic          edo,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic          pend;
    logic [DW-1:0] cap;

    // Present read data: directly in normal timing, from the half-cycle latch in EDO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pend     <= samp & edo;
            rd_valid <= (samp & ~edo) | pend;
            if (samp & ~edo)
                rd_data <= dq_in;
            else if (pend)
                rd_data <= cap;
        end
    end

    // Half-clock-late sample for EDO parts.
    always_ff @(negedge clk) begin
        if (pend)
            cap <= dq_in;
    end

    // R8: a pending EDO sample always produces valid data on the next edge.
    p_edo_delivers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> rd_valid);
endmodule

// File: rtl/dram_area_ctrl.sv
// Dual-area DRAM controller: sequences row open, fast-page CAS beats,
// precharge and CAS-before-RAS refresh for areas 2 and 3.
// Assumes: the map, width and EDO inputs are held stable while not idle;
// all strobes are registered from the next-state decode.
module dram_area_ctrl
    import dram_area_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int DW     = 32,
    localparam int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dram_map,
    input  logic              a3_wide32,
    input  logic              edo_en,
    input  logic              req_valid,
    input  logic              req_area,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [1:0]        req_len,
    output logic              req_ack,
    output logic              beat_rdy,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    input  logic              refresh_req,
    output logic              refresh_ack,
    output logic              ras_n,
    output logic              ras2_n,
    output logic [3:0]        cas_n,
    output logic [1:0]        cas2_n,
    output logic              dram_we_n,
    output logic [MA_W-1:0]   dram_addr,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    input  logic [DW-1:0]     dq_in
);
    dstate_t st, nxt;

    logic a3_ok, a2_ok, area_ok, in_idle, acc_go, ref_go, last_beat;
    logic a3_q, wr_q, wide_q, two_q, edo_q;
    logic a3_d, wr_d, wide_d, two_d, edo_d;
    logic [3:0] be_q, be_d;
    logic [1:0] len_q, len_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic act_n, cas_on, cbr_on;
    logic [3:0] a3_lanes;
    logic [1:0] a2_lanes;
    logic [MA_W-1:0] ma_d;

    // Map decode and request/refresh acceptance.
    always_comb begin
        a3_ok       = (dram_map == MAP_A3_ONLY) || (dram_map == MAP_BOTH);
        a2_ok       = (dram_map == MAP_BOTH);
        area_ok     = req_area ? a3_ok : a2_ok;
        in_idle     = (st == ST_IDLE);
        ref_go      = in_idle & refresh_req & a3_ok;
        acc_go      = in_idle & req_valid & area_ok & ~refresh_req;
        req_ack     = acc_go;
        refresh_ack = ref_go;
        beat_rdy    = (st == ST_DATA);
        last_beat   = (beat_q == BEAT_W'((4'd1 << len_q) - 4'd1));
        dq_out      = wdata;
    end

    // Next values of the latched request fields.
    always_comb begin
        a3_d = a3_q; wr_d = wr_q; wide_d = wide_q; two_d = two_q; edo_d = edo_q;
        be_d = be_q; len_d = len_q; row_d = row_q; col_d = col_q;
        if (acc_go) begin
            a3_d  = req_area;
            wr_d  = req_write;
            edo_d = edo_en & req_area;
            be_d  = req_be;
            len_d = req_len;
            row_d = req_addr[ADDR_W-1:COL_W];
            col_d = req_addr[COL_W-1:0];
        end else if (ref_go) begin
            wr_d  = 1'b0;
        end
        if (acc_go | ref_go) begin
            two_d  = a2_ok;
            wide_d = a3_wide32 & ~a2_ok;
        end
        if (acc_go)
            beat_d = '0;
        else if ((st == ST_DATA) && !last_beat)
            beat_d = beat_q + 1'b1;
        else
            beat_d = beat_q;
    end

    // Sequencer next state.
    always_comb begin
        case (st)
            ST_IDLE:  nxt = ref_go ? ST_CBR_C : (acc_go ? ST_ROW : ST_IDLE);
            ST_ROW:   nxt = ST_COL;
            ST_COL:   nxt = ST_DATA;
            ST_DATA:  nxt = last_beat ? ST_PRE : ST_CGAP;
            ST_CGAP:  nxt = ST_COL;
            ST_CBR_C: nxt = ST_CBR_R;
            ST_CBR_R: nxt = ST_PRE;
            default:  nxt = ST_IDLE;
        endcase
        act_n  = !(nxt inside {ST_ROW, ST_COL, ST_DATA, ST_CGAP});
        cas_on = (nxt inside {ST_COL, ST_DATA});
        cbr_on = (nxt inside {ST_CBR_C, ST_CBR_R});
    end

    dram_lane_decode u_lanes (
        .to_a3    (a3_d),
        .wide     (wide_d),
        .two_area (two_d),
        .cbr      (cbr_on),
        .be       (be_d),
        .a3_lanes (a3_lanes),
        .a2_lanes (a2_lanes)
    );

    dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .BEAT_W(BEAT_W)) u_amux (
        .sel_row (nxt == ST_ROW),
        .row     (row_d),
        .col     (col_d),
        .beat    (beat_d),
        .ma      (ma_d)
    );

    // State, latched request and registered DRAM pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            a3_q <= 1'b0; wr_q <= 1'b0; wide_q <= 1'b0; two_q <= 1'b0; edo_q <= 1'b0;
            be_q <= '0; len_q <= '0; row_q <= '0; col_q <= '0; beat_q <= '0;
            ras_n <= 1'b1; ras2_n <= 1'b1; cas_n <= 4'hF; cas2_n <= 2'b11;
            dram_we_n <= 1'b1; dq_oe <= 1'b0; dram_addr <= '0;
        end else begin
            st <= nxt;
            a3_q <= a3_d; wr_q <= wr_d; wide_q <= wide_d; two_q <= two_d; edo_q <= edo_d;
            be_q <= be_d; len_q <= len_d; row_q <= row_d; col_q <= col_d; beat_q <= beat_d;
            ras_n     <= !((!act_n & a3_d) | (nxt == ST_CBR_R));
            ras2_n    <= !((!act_n & !a3_d) | ((nxt == ST_CBR_R) & two_d));
            cas_n     <= ~((cas_on | cbr_on) ? a3_lanes : 4'h0);
            cas2_n    <= ~((cas_on | cbr_on) ? a2_lanes : 2'b00);
            dram_we_n <= !(!act_n & wr_d);
            dq_oe     <= cas_on & wr_d;
            dram_addr <= ma_d;
        end
    end

    dram_edo_capture #(.DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp     ((st == ST_DATA) & ~wr_q),
        .edo      (edo_q),
        .dq_in    (dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R2: a 16-bit area 3 never strobes the upper lanes.
    p_upper_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |-> (&cas_n[3:2]));
    // R6: RAS stays high at least one clock after rising.
    p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    // R11: CAS low with every RAS high happens only in the first refresh cycle.
    p_cbr_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&{cas_n, cas2_n}) && ras_n && ras2_n) |-> (st == ST_CBR_C));
    // R3: both RAS lines low together only during refresh.
    p_area_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !ras2_n) |-> (st == ST_CBR_R));
    // R1: an unmapped configuration keeps the RAS lines idle.
    p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !a3_ok) |=> (ras_n && ras2_n));
    // R7: read-valid is a single-cycle pulse.
    p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/dram_area_ctrl_test.sv
module dram_area_ctrl_test;
    localparam int ROW_W = 10;
    localparam int COL_W = 8;
    localparam int MA_W  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] dram_map = 3'b000;
    logic a3_wide32 = 1'b0, edo_en = 1'b0;
    logic req_valid = 1'b0, req_area = 1'b0, req_write = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [3:0] req_be = 4'h0;
    logic [1:0] req_len = 2'd0;
    logic [31:0] wdata = '0, dq_in = '0;
    logic refresh_req = 1'b0;
    logic req_ack, beat_rdy, rd_valid, refresh_ack, ras_n, ras2_n, dram_we_n, dq_oe;
    logic [31:0] rd_data, dq_out;
    logic [3:0] cas_n;
    logic [1:0] cas2_n;
    logic [MA_W-1:0] dram_addr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_area_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .dram_map(dram_map), .a3_wide32(a3_wide32),
        .edo_en(edo_en), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_len(req_len), .req_ack(req_ack), .beat_rdy(beat_rdy),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .refresh_req(refresh_req), .refresh_ack(refresh_ack),
        .ras_n(ras_n), .ras2_n(ras2_n), .cas_n(cas_n), .cas2_n(cas2_n),
        .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in)
    );

    function automatic logic [31:0] fdata(input logic [MA_W-1:0] a);
        return (32'(a) * 32'h0001_0003) ^ 32'hC3C3_0000;
    endfunction

    // DRAM model: drives data for the strobed column, holds it after CAS rises.
    always @(negedge clk)
        if (!(&cas_n) || !(&cas2_n)) dq_in <= fdata(dram_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic idle_strobes(input string tag);
        chk(tag, {ras_n, ras2_n, cas_n, cas2_n, dram_we_n}, 9'h1FF);
    endtask

    // One access, checked cycle by cycle against the requirements.
    task automatic run_access(input logic [2:0] map, input bit wide, input bit area,
                              input bit wr, input int len, input logic [3:0] be,
                              input bit edo, input logic [ROW_W-1:0] row,
                              input logic [COL_W-1:0] col);
        bit ok = area ? (map == 3'b100 || map == 3'b101) : (map == 3'b101);
        bit widex = wide && (map == 3'b100);
        bit edox = edo && area;
        int nb = 1 << len;
        int beats = 0, reads = 0, rdy_cyc = 0;
        logic [3:0] exp_cas = !area ? 4'hF : (widex ? ~be : {2'b11, ~be[1:0]});
        logic [1:0] exp_cas2 = area ? 2'b11 : ~be[1:0];
        dram_map = map; a3_wide32 = wide; edo_en = edo;
        req_valid = 1'b1; req_area = area; req_write = wr; req_be = be;
        req_len = 2'(len); req_addr = {row, col}; wdata = fdata(MA_W'(row)) ^ 32'h5555_AAAA;
        #1 chk("R1 req_ack", 32'(req_ack), 32'(ok));
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            for (int i = 0; i < 3; i++) begin
                idle_strobes("R1 ignored request strobes");
                @(negedge clk);
            end
            return;
        end
        chk("R4 row cycle RAS/CAS", {ras_n, ras2_n, cas_n, cas2_n}, {!area, area, 6'h3F});
        chk("R4 row address", 32'(dram_addr), 32'(row));
        for (int c = 2; c <= 3 * nb + 2; c++) begin
            @(negedge clk);
            if (beat_rdy) begin
                chk(area ? "R2 area3 lanes" : "R3 area2 lanes", {cas_n, cas2_n}, {exp_cas, exp_cas2});
                chk("R5 beat column", 32'(dram_addr), 32'(8'(col + 8'(beats))));
                chk("R5 RAS held", {ras_n, ras2_n}, {!area, area});
                chk("R9 write line/oe", {dram_we_n, dq_oe}, {!wr, wr});
                if (wr) chk("R9 write data", dq_out, wdata);
                rdy_cyc = c;
                beats++;
            end else if (c > 1 && beats < nb && c % 3 == 1) begin
                chk("R5 CAS gap between beats", {cas_n, cas2_n}, 6'h3F);
            end
            if (rd_valid) begin
                chk(edox ? "R8 EDO read latency" : "R7 read latency", 32'(c - rdy_cyc), edox ? 2 : 1);
                chk(edox ? "R8 EDO read data" : "R7 read data", rd_data,
                    fdata(MA_W'(8'(col + 8'(reads)))));
                reads++;
            end
        end
        chk("R5 beat count", 32'(beats), 32'(nb));
        chk("R7 read count", 32'(reads), wr ? 0 : 32'(nb));
        @(negedge clk);
        idle_strobes("R6 precharge after burst");
    endtask

    task automatic run_refresh(input logic [2:0] map, input bit wide);
        bit ok = (map == 3'b100 || map == 3'b101);
        bit two = (map == 3'b101);
        logic [3:0] ec = (map == 3'b100 && wide) ? 4'h0 : 4'hC;
        dram_map = map; a3_wide32 = wide; refresh_req = 1'b1;
        #1 chk("R11 refresh_ack", 32'(refresh_ack), 32'(ok));
        @(negedge clk);
        refresh_req = 1'b0;
        if (!ok) begin
            idle_strobes("R1 refresh on unmapped");
            return;
        end
        chk("R11 CAS before RAS", {ras_n, ras2_n, cas_n, cas2_n}, {2'b11, ec, two ? 2'b00 : 2'b11});
        @(negedge clk);
        chk("R11 RAS lines in refresh", {ras_n, ras2_n, cas_n, cas2_n}, {1'b0, !two, ec, two ? 2'b00 : 2'b11});
        @(negedge clk);
        idle_strobes("R11 refresh precharge");
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_strobes("R10 reset strobes");
        chk("R10 reset outputs", {beat_rdy, rd_valid, dq_oe}, 3'b000);

        // Sweep: map, area, width, direction, burst code, read timing.
        for (int idx = 0; idx < 128; idx++) begin
            logic [3:0] be_tab [4] = '{4'hF, 4'h5, 4'hA, 4'h3};
            run_access((idx & 1) ? 3'b101 : 3'b100, idx[1], idx[2], idx[3],
                       (idx >> 4) & 3, be_tab[(idx >> 2) & 3], idx[6],
                       ROW_W'(idx * 37 + 5), COL_W'(8'hFA + (idx % 8)));
        end

        // R1: unmapped values ignore both areas.
        begin
            logic [2:0] bad [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
            for (int k = 0; k < 6; k++) begin
                run_access(bad[k], 1'b1, 1'b1, 1'b0, 0, 4'hF, 1'b0, 10'h3, 8'h1);
                run_access(bad[k], 1'b0, 1'b0, 1'b1, 1, 4'h3, 1'b0, 10'h4, 8'h2);
            end
        end

        // R11: refresh on each mapping.
        run_refresh(3'b100, 1'b1);
        run_refresh(3'b100, 1'b0);
        run_refresh(3'b101, 1'b1);
        run_refresh(3'b000, 1'b1);

        // R11: refresh wins over a simultaneous access.
        dram_map = 3'b100; a3_wide32 = 1'b1; edo_en = 1'b0;
        req_valid = 1'b1; req_area = 1'b1; req_write = 1'b0; req_len = 2'd0;
        refresh_req = 1'b1;
        #1 chk("R11 refresh priority", {refresh_ack, req_ack}, 2'b10);
        @(negedge clk);
        refresh_req = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R11: refresh is deferred until the access ends.
        req_valid = 1'b1; req_addr = '0; req_be = 4'hF;
        @(negedge clk);
        req_valid = 1'b0; refresh_req = 1'b1;
        #1 chk("R11 no refresh while busy", 32'(refresh_ack), 0);
        begin
            int seen = 0;
            for (int c = 2; c <= 8 && seen == 0; c++) begin
                @(negedge clk);
                #1 if (refresh_ack) seen = c;
            end
            chk("R11 refresh taken at idle", 32'(seen), 5);
        end
        @(negedge clk);
        refresh_req = 1'b0;
        repeat (4) @(negedge clk);
        idle_strobes("R6 final idle");
        finish_run();
    end
endmodule